// File: doc/BRIEF.md
# Video Parallel Output Formatter

This block takes one luma sample and one chroma sample per accepted pair and drives a parallel video bus. The bus runs in one of three formats. The split format uses all 20 bits, with the two samples side by side. The sequential format puts chroma and then luma on a 10-bit lane over two clock cycles, so a chroma stream that alternates Cb and Cr comes out as Cb, Y, Cr, Y. The dual-edge format is used at the top video rate on the 10-bit lane. It launches chroma on the rising edge and luma on the falling edge, so one pair leaves in each clock period. Here the two edge words are presented as two ports that are valid for the same clock period.

The upstream source offers a pair by raising `in_valid`, and the pair is taken only in a cycle where `take` is high. The bus-width and rate selects are sampled only at a pair boundary, so a luma/chroma pair is never split across two formats. From the sampled settings the block reports the class of output clock the downstream side must run at. A standby input freezes the block: the bus holds its last value and nothing is sampled.

Top module: `vfmt_par_out`

## Requirements
- R1: After reset `vbus` and `ddr_fall` are zero, `clk_class` is 0, `ddr_active` is 0, and the sampled configuration is the split format at the SD rate.
- R2: Split format (`wide_sel`=1): a pair taken at a clock edge appears after that edge as `vbus[19:10]`=luma and `vbus[9:0]`=chroma, with `ddr_fall`=0.
- R3: Sequential format (`wide_sel`=0, `rate_sel` 0=SD or 1=HD): after the taking edge `vbus[9:0]`=chroma, and after the next edge `vbus[9:0]`=luma. `vbus[19:10]`=0 and `ddr_fall`=0 throughout. `take` is low in the cycle between the two edges.
- R4: Dual-edge format (`wide_sel`=0, `rate_sel` 2 or 3): after the taking edge `vbus[9:0]`=chroma (the rising-edge word), `ddr_fall`=luma (the falling-edge word) and `vbus[19:10]`=0. A new pair can be taken in every cycle.
- R5: `clk_class` encodes the output clock: 0=13.5 MHz (SD split), 1=27 MHz (SD sequential), 2=74.25 MHz (HD split), 3=148.5 MHz (HD sequential, or any width at the top rate). `ddr_active` is 1 exactly when the dual-edge format is sampled.
- R6: `take` equals `!standby` outside the second half of a sequential pair. The selects are sampled only at an edge where `take` is high, and a change while `take` is low has no effect on the word in progress.
- R7: While `standby` is high, `take` is low, `vbus`, `ddr_fall` and `clk_class` hold their values, and a pair left half-sent resumes with its luma word once standby drops.
- R8: At a boundary edge with `in_valid` low, `vbus` and `ddr_fall` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Freeze: hold the outputs and sample nothing |
| wide_sel | input | 1 | 1 = 20-bit split bus, 0 = 10-bit lane |
| rate_sel | input | 2 | Video rate: 0 SD, 1 HD, 2 or 3 top rate |
| in_valid | input | 1 | A sample pair is offered |
| in_luma | input | 10 | Luma sample |
| in_chroma | input | 10 | Chroma sample (Cb or Cr) |
| take | output | 1 | The offered pair is accepted at the next edge |
| vbus | output | 20 | Parallel video bus (rising-edge word in dual-edge format) |
| ddr_fall | output | 10 | Falling-edge word in dual-edge format, else 0 |
| clk_class | output | 2 | Output clock class, encoded as in R5 |
| ddr_active | output | 1 | The dual-edge format is sampled |

## Verification
The bench goes after a select change in the middle of a sequential pair. A design that samples the selects on every edge would put the luma of that pair into the wrong format or drop it. It also raises standby between the chroma and luma words. A design that resets its pair phase there would lose the luma, and one that keeps running would change the bus while it should be frozen. Idle boundary cycles catch a bus that clears or repeats data without a pair. Long random runs across all width and rate settings catch clock classes that are mapped wrongly and edge words that are swapped.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    typedef enum logic [1:0] {
        RATE_SD     = 2'd0,
        RATE_HD     = 2'd1,
        RATE_TOP    = 2'd2,
        RATE_TOP_B  = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        CLK_13M5  = 2'd0,
        CLK_27M   = 2'd1,
        CLK_74M25 = 2'd2,
        CLK_148M5 = 2'd3
    } clk_class_e;

    typedef enum logic [1:0] {
        FMT_SPLIT = 2'd0,
        FMT_DUAL  = 2'd1,
        FMT_SEQ   = 2'd2
    } fmt_e;

    typedef struct packed {
        logic  wide;
        rate_e rate;
    } bus_cfg_t;

    localparam bus_cfg_t CFG_RESET = '{wide: 1'b1, rate: RATE_SD};

    function automatic logic is_top_rate(input rate_e r);
        return r[1];
    endfunction

    function automatic fmt_e fmt_of(input bus_cfg_t c);
        if (c.wide)                return FMT_SPLIT;
        else if (is_top_rate(c.rate)) return FMT_DUAL;
        else                       return FMT_SEQ;
    endfunction

    function automatic clk_class_e class_of(input bus_cfg_t c);
        case (c.rate)
            RATE_SD: return c.wide ? CLK_13M5  : CLK_27M;
            RATE_HD: return c.wide ? CLK_74M25 : CLK_148M5;
            default: return CLK_148M5;
        endcase
    endfunction

endpackage

// File: rtl/vfmt_mode_ctl.sv
module vfmt_mode_ctl
    import vfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  logic       in_valid,
    input  logic       wide_sel,
    input  logic [1:0] rate_sel,
    output logic       take,
    output logic       second_half,
    output fmt_e       fmt_now,
    output bus_cfg_t   cfg_q
);
    logic     half_q;
    bus_cfg_t cfg_eff;
    bus_cfg_t cfg_in;

    always_comb begin
        cfg_in.wide = wide_sel;
        cfg_in.rate = rate_e'(rate_sel);
        cfg_eff     = half_q ? cfg_q : cfg_in;
        fmt_now     = fmt_of(cfg_eff);
        take        = !standby && !half_q;
        second_half = half_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            cfg_q  <= CFG_RESET;
        end else if (!standby) begin
            if (!half_q) begin
                cfg_q  <= cfg_eff;
                half_q <= in_valid && (fmt_of(cfg_eff) == FMT_SEQ);
            end else begin
                half_q <= 1'b0;
            end
        end
    end

    // R3: a sequential pair blocks acceptance for one cycle
    assert_seq_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (take && in_valid && fmt_now == FMT_SEQ) |=> !take);

    // R6: configuration is frozen during the second half of a pair
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        half_q |=> $stable(cfg_q));

    // R7: no acceptance during standby
    assert_standby_no_take_R7: assert property (@(posedge clk) disable iff (rst)
        standby |-> !take);
endmodule

// File: rtl/vfmt_lane_pack.sv
module vfmt_lane_pack
    import vfmt_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    localparam int BUS_W   = 2 * SAMPLE_W
) (
    input  logic                take,
    input  logic                in_valid,
    input  logic                second_half,
    input  logic                standby,
    input  fmt_e                fmt_now,
    input  logic [SAMPLE_W-1:0] luma,
    input  logic [SAMPLE_W-1:0] chroma,
    input  logic [SAMPLE_W-1:0] held_luma,
    output logic [BUS_W-1:0]    nxt_bus,
    output logic [SAMPLE_W-1:0] nxt_fall,
    output logic                load,
    output logic                capture
);
    localparam logic [SAMPLE_W-1:0] ZERO_W = '0;

    logic accept;

    always_comb begin
        accept   = take && in_valid;
        load     = accept || (second_half && !standby);
        capture  = accept && (fmt_now == FMT_SEQ);
        nxt_bus  = {ZERO_W, chroma};
        nxt_fall = ZERO_W;
        if (second_half) begin
            nxt_bus = {ZERO_W, held_luma};
        end else begin
            case (fmt_now)
                FMT_SPLIT: nxt_bus  = {luma, chroma};
                FMT_DUAL:  nxt_fall = luma;
                default:   nxt_bus  = {ZERO_W, chroma};
            endcase
        end
    end
endmodule

// File: rtl/vfmt_out_reg.sv
module vfmt_out_reg #(
    parameter int SAMPLE_W = 10,
    localparam int BUS_W   = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                capture,
    input  logic [BUS_W-1:0]    nxt_bus,
    input  logic [SAMPLE_W-1:0] nxt_fall,
    input  logic [SAMPLE_W-1:0] luma,
    output logic [BUS_W-1:0]    bus_q,
    output logic [SAMPLE_W-1:0] fall_q,
    output logic [SAMPLE_W-1:0] held_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q  <= '0;
            fall_q <= '0;
            held_q <= '0;
        end else begin
            if (load) begin
                bus_q  <= nxt_bus;
                fall_q <= nxt_fall;
            end
            if (capture) held_q <= luma;
        end
    end

    // R8: registers move only when loaded
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(bus_q) && $stable(fall_q)));
endmodule

// File: rtl/vfmt_par_out.sv
module vfmt_par_out
    import vfmt_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    localparam int BUS_W   = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                standby,
    input  logic                wide_sel,
    input  logic [1:0]          rate_sel,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_luma,
    input  logic [SAMPLE_W-1:0] in_chroma,
    output logic                take,
    output logic [BUS_W-1:0]    vbus,
    output logic [SAMPLE_W-1:0] ddr_fall,
    output logic [1:0]          clk_class,
    output logic                ddr_active
);
    logic                second_half;
    fmt_e                fmt_now;
    bus_cfg_t            cfg_q;
    logic [BUS_W-1:0]    nxt_bus;
    logic [SAMPLE_W-1:0] nxt_fall;
    logic [SAMPLE_W-1:0] held_luma;
    logic                load;
    logic                capture;

    vfmt_mode_ctl i_ctl (
        .clk(clk), .rst(rst), .standby(standby), .in_valid(in_valid),
        .wide_sel(wide_sel), .rate_sel(rate_sel), .take(take),
        .second_half(second_half), .fmt_now(fmt_now), .cfg_q(cfg_q)
    );

    vfmt_lane_pack #(.SAMPLE_W(SAMPLE_W)) i_pack (
        .take(take), .in_valid(in_valid), .second_half(second_half),
        .standby(standby), .fmt_now(fmt_now), .luma(in_luma),
        .chroma(in_chroma), .held_luma(held_luma), .nxt_bus(nxt_bus),
        .nxt_fall(nxt_fall), .load(load), .capture(capture)
    );

    vfmt_out_reg #(.SAMPLE_W(SAMPLE_W)) i_out (
        .clk(clk), .rst(rst), .load(load), .capture(capture),
        .nxt_bus(nxt_bus), .nxt_fall(nxt_fall), .luma(in_luma),
        .bus_q(vbus), .fall_q(ddr_fall), .held_q(held_luma)
    );

    always_comb begin
        clk_class  = class_of(cfg_q);
        ddr_active = (fmt_of(cfg_q) == FMT_DUAL);
    end

    // R2: split format puts luma high, chroma low
    assert_split_halves_R2: assert property (@(posedge clk) disable iff (rst)
        (take && in_valid && wide_sel) |=>
        (vbus == {$past(in_luma), $past(in_chroma)} && ddr_fall == '0));

    // R4: dual-edge format carries luma as the falling-edge word
    assert_dual_words_R4: assert property (@(posedge clk) disable iff (rst)
        (take && in_valid && !wide_sel && rate_sel[1]) |=>
        (ddr_fall == $past(in_luma) && vbus[SAMPLE_W-1:0] == $past(in_chroma)
         && vbus[BUS_W-1:SAMPLE_W] == '0));

    // R5: dual-edge format always runs at the top clock class
    assert_dual_class_R5: assert property (@(posedge clk) disable iff (rst)
        ddr_active |-> (clk_class == 2'd3));

    // R7: standby freezes the outputs
    assert_standby_hold_R7: assert property (@(posedge clk) disable iff (rst)
        standby |=> ($stable(vbus) && $stable(ddr_fall) && $stable(clk_class)));
endmodule

// File: tb/test_vfmt_par_out.sv
module test_vfmt_par_out;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic        wide_sel = 1'b1;
    logic [1:0]  rate_sel = 2'd0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_luma = '0;
    logic [9:0]  in_chroma = '0;
    logic        take;
    logic [19:0] vbus;
    logic [9:0]  ddr_fall;
    logic [1:0]  clk_class;
    logic        ddr_active;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          m_half = 0;
    logic        m_w = 1'b1;
    logic [1:0]  m_r = 2'd0;
    logic [9:0]  m_held = '0;
    logic [19:0] m_bus = '0;
    logic [9:0]  m_fall = '0;
    string       m_tag = "R1";

    always #2 clk = ~clk;

    vfmt_par_out i_vfmt_par_out (
        .clk(clk), .rst(rst), .standby(standby), .wide_sel(wide_sel),
        .rate_sel(rate_sel), .in_valid(in_valid), .in_luma(in_luma),
        .in_chroma(in_chroma), .take(take), .vbus(vbus), .ddr_fall(ddr_fall),
        .clk_class(clk_class), .ddr_active(ddr_active)
    );

    task automatic check(input string tag, input string what,
                         input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_class(input logic w, input logic [1:0] r);
        if (r >= 2) return 2'd3;
        if (r == 1) return w ? 2'd2 : 2'd3;
        return w ? 2'd0 : 2'd1;
    endfunction

    task automatic step(input logic sb, input logic v, input logic w,
                        input logic [1:0] r, input logic [9:0] y, input logic [9:0] c);
        @(negedge clk);
        standby = sb; in_valid = v; wide_sel = w; rate_sel = r;
        in_luma = y; in_chroma = c;
        #1;
        check("R6", "take", {19'd0, take}, {19'd0, (!sb && m_half == 0)});
        if (sb) begin
            m_tag = "R7";
        end else if (m_half != 0) begin
            m_bus = {10'd0, m_held}; m_fall = '0; m_half = 0; m_tag = "R3";
        end else begin
            m_w = w; m_r = r;
            if (!v) m_tag = "R8";
            else if (w) begin
                m_bus = {y, c}; m_fall = '0; m_tag = "R2";
            end else if (r >= 2) begin
                m_bus = {10'd0, c}; m_fall = y; m_tag = "R4";
            end else begin
                m_bus = {10'd0, c}; m_fall = '0; m_held = y; m_half = 1; m_tag = "R3";
            end
        end
        @(posedge clk);
        #1;
        check(m_tag, "vbus", vbus, m_bus);
        check(m_tag, "ddr_fall", {10'd0, ddr_fall}, {10'd0, m_fall});
        check("R5", "clk_class", {18'd0, clk_class}, {18'd0, exp_class(m_w, m_r)});
        check("R5", "ddr_active", {19'd0, ddr_active}, {19'd0, (!m_w && m_r >= 2)});
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "vbus", vbus, 20'd0);
        check("R1", "ddr_fall", {10'd0, ddr_fall}, 20'd0);
        check("R1", "clk_class", {18'd0, clk_class}, 20'd0);
        check("R1", "ddr_active", {19'd0, ddr_active}, 20'd0);
        check("R1", "take", {19'd0, take}, 20'd1);

        // R2 split, R8 idle hold
        step(0, 1, 1, 0, 10'h3AA, 10'h155);
        step(0, 0, 1, 0, 10'h001, 10'h002);
        step(0, 1, 1, 1, 10'h111, 10'h222);
        // R3 sequence Cb,Y,Cr,Y with a mid-pair select change (R6)
        step(0, 1, 0, 0, 10'h040, 10'h200);
        step(0, 1, 1, 2, 10'h3FF, 10'h3FF);
        step(0, 1, 0, 0, 10'h041, 10'h201);
        step(0, 0, 0, 0, 10'h000, 10'h000);
        // R4 dual-edge, back to back
        step(0, 1, 0, 2, 10'h0AB, 10'h0CD);
        step(0, 1, 0, 3, 10'h1AB, 10'h1CD);
        // R7 standby in the middle of a sequential pair
        step(0, 1, 0, 1, 10'h2EE, 10'h1DD);
        step(1, 1, 1, 2, 10'h000, 10'h000);
        step(1, 0, 1, 0, 10'h000, 10'h000);
        step(0, 1, 1, 2, 10'h123, 10'h321);
        step(0, 1, 1, 2, 10'h0F0, 10'h00F);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] dice;
            dice = 4'($urandom_range(0, 15));
            step(dice == 0, dice != 1, $urandom_range(0, 1) == 1,
                 2'($urandom_range(0, 3)), 10'($urandom), 10'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule